// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands direction control of a bidirectional serial data lane between its two ends while the lane is in low-power signalling. Each of the two single-ended line wires is seen as one bit of a two-bit line state. When the block holds the lane and a turnaround is requested, it plays the handover pattern on the wires: first-wire-high, both-low, first-wire-high, then a long both-low bridge. After that it stops driving and waits for the far end to finish claiming the lane.

When the block does not hold the lane, it watches the synchronized wires for the same pattern coming from the far end. After the final bridge appears, it waits a settle interval and then starts driving the bridge itself. It then drives first-wire-high, then the stop state, and raises its ownership flag. All intervals are counted in a programmable base unit, given in clock cycles, that has a hard floor. If an expected line change does not arrive within a programmable number of cycles, the block flags an error and waits for the stop state.

Top module: `lane_turnaround`

## Requirements
- R1: After reset the block owns the lane. It drives (`lp_oe`=1) the stop state `lp_out`=2'b11 with `owner`=1 and `ta_err`=0. Line bits are {first wire, second wire}: 2'b10 is first-wire-high, 2'b00 is both-low (bridge).
- R2: While owning and stopped, one cycle of `ta_req` starts the give pattern. The block drives 2'b10, 2'b00 and 2'b10 for U cycles each, then 2'b00 for 4·U cycles. In the next cycle `lp_oe` and `owner` fall together. `owner` stays 1 for the whole pattern.
- R3: The base unit is U = max(`cfg_lpx`, LPX_MIN), with LPX_MIN = 13 cycles by default (at least 50 ns at 250 MHz).
- R4: `ta_req` has no effect while the block does not own the lane: `lp_oe` stays 0.
- R5: When not owning and idle on a 2'b11 line, the block accepts the sequence 2'b10, 2'b00, 2'b10, 2'b00 on `lp_in` after SYNC_STAGES flip-flops of synchronization. On the final 2'b00 it waits the settle time and then raises `lp_oe`, driving 2'b00 first. `lp_oe` first reads 1 at SYNC_STAGES + 1 + settle clock edges after that 2'b00 is applied.
- R6: The settle time is `cfg_sure` clamped to the range [U, 2·U].
- R7: On taking the lane, the block drives 2'b00 for 5·U cycles and then 2'b10 for U cycles. It then drives 2'b11 and raises `owner` in the same cycle.
- R8: In a waiting state of the receive sequence, or after release, the line may stay unchanged for `cfg_timeout` cycles. When that happens, `ta_err` pulses for exactly one cycle (with `lp_oe`=0), and the block waits for a 2'b11 line before listening again.
- R9: If the line returns to 2'b11 part way through the receive sequence, the block goes back to idle listening without an error and without driving.
- R10: After giving the lane, the far end's claim (bridge, 2'b10, then 2'b11 within the timeout) returns the block to idle listening with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lpx | input | LPX_W | Base unit in cycles (floored at LPX_MIN) |
| cfg_sure | input | LPX_W+1 | Settle time in cycles before taking the lane |
| cfg_timeout | input | TMO_W | Cycles a waiting state may see no line change |
| ta_req | input | 1 | Request to hand the lane to the far end |
| lp_in | input | 2 | Observed line wires {first, second}, asynchronous |
| lp_out | output | 2 | Line state driven when lp_oe is 1 |
| lp_oe | output | 1 | Drive enable for the line wires |
| owner | output | 1 | The block holds the lane |
| ta_err | output | 1 | One-cycle pulse on a missing line transition |

## Verification
A wrong state shows up at the ports as a wrong run length or a wrong run order of `lp_out` while `lp_oe` is high. It also shows up as `lp_oe` rising at the wrong edge after the far end's final bridge, because the settle count is exact to the cycle. A state machine stuck in a receive state can only surface as a `ta_err` pulse, which comes `cfg_timeout` cycles later, or as a missing takeover. For this reason the bench checks both the absence of errors on clean handovers and the error window on stalled ones.

// File: rtl/lta_pkg.sv
package lta_pkg;

    typedef enum logic [1:0] {
        LN_00 = 2'b00,
        LN_01 = 2'b01,
        LN_10 = 2'b10,
        LN_11 = 2'b11
    } lp_line_t;

    typedef enum logic [3:0] {
        S_OWN_STOP,
        S_G_10A,
        S_G_00A,
        S_G_10B,
        S_G_BRIDGE,
        S_R_RETURN,
        S_RESYNC,
        S_IDLE,
        S_R_10A,
        S_R_00A,
        S_R_10B,
        S_R_SETTLE,
        S_T_BRIDGE,
        S_T_10
    } lta_state_t;

    typedef struct packed {
        logic     oe;
        lp_line_t line;
        logic     owner;
    } lta_drive_t;

    function automatic lta_drive_t drive_of(lta_state_t st);
        lta_drive_t d;
        d = '{oe: 1'b0, line: LN_11, owner: 1'b0};
        case (st)
            S_OWN_STOP: d = '{oe: 1'b1, line: LN_11, owner: 1'b1};
            S_G_10A:    d = '{oe: 1'b1, line: LN_10, owner: 1'b1};
            S_G_00A:    d = '{oe: 1'b1, line: LN_00, owner: 1'b1};
            S_G_10B:    d = '{oe: 1'b1, line: LN_10, owner: 1'b1};
            S_G_BRIDGE: d = '{oe: 1'b1, line: LN_00, owner: 1'b1};
            S_T_BRIDGE: d = '{oe: 1'b1, line: LN_00, owner: 1'b0};
            S_T_10:     d = '{oe: 1'b1, line: LN_10, owner: 1'b0};
            default:    d = '{oe: 1'b0, line: LN_11, owner: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic is_timed(lta_state_t st);
        return (st == S_R_10A) || (st == S_R_00A) ||
               (st == S_R_10B) || (st == S_R_RETURN);
    endfunction

endpackage

// File: rtl/lta_sync.sv
module lta_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg[i] <= RST_VAL;
                    end else if (i == 0) begin
                        stg[i] <= d;
                    end else begin
                        stg[i] <= stg[(i == 0) ? 0 : i-1];
                    end
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lta_timing.sv
module lta_timing #(
    parameter int LPX_W   = 8,
    parameter int LPX_MIN = 13,
    parameter int DW      = LPX_W + 3
) (
    input  logic [LPX_W-1:0] cfg_lpx,
    input  logic [LPX_W:0]   cfg_sure,
    output logic [DW-1:0]    unit_len,
    output logic [DW-1:0]    settle_len,
    output logic [DW-1:0]    bridge_len,
    output logic [DW-1:0]    claim_len
);
    localparam logic [LPX_W-1:0] FLOOR = LPX_W'(LPX_MIN);

    logic [LPX_W-1:0] unit_e;
    logic [LPX_W:0]   unit_x;
    logic [LPX_W:0]   twice;
    logic [LPX_W:0]   settle_e;

    always_comb begin
        unit_e = (cfg_lpx < FLOOR) ? FLOOR : cfg_lpx;
        unit_x = {1'b0, unit_e};
        twice  = {unit_e, 1'b0};
        if (cfg_sure < unit_x) begin
            settle_e = unit_x;
        end else if (cfg_sure > twice) begin
            settle_e = twice;
        end else begin
            settle_e = cfg_sure;
        end
        unit_len   = DW'(unit_e);
        settle_len = DW'(settle_e);
        bridge_len = DW'({unit_e, 2'b00});
        claim_len  = DW'({unit_e, 2'b00}) + DW'(unit_e);
    end
endmodule

// File: rtl/lta_fsm.sv
module lta_fsm
    import lta_pkg::*;
#(
    parameter int DW          = 11,
    parameter int TMO_W       = 16,
    parameter bit RESET_OWNER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ta_req,
    input  lp_line_t         line,
    input  logic [DW-1:0]    unit_len,
    input  logic [DW-1:0]    settle_len,
    input  logic [DW-1:0]    bridge_len,
    input  logic [DW-1:0]    claim_len,
    input  logic [TMO_W-1:0] timeout,
    output lta_drive_t       drv,
    output logic             err
);
    localparam logic [DW-1:0]    ONE_D   = DW'(1);
    localparam logic [TMO_W:0]   ONE_T   = (TMO_W+1)'(1);
    localparam lta_state_t       ST_RST  = RESET_OWNER ? S_OWN_STOP : S_RESYNC;

    lta_state_t       st, nxt;
    logic [DW-1:0]    dwell, load_val;
    logic             load;
    logic [TMO_W-1:0] hold;
    logic [TMO_W:0]   hold_nx;
    lp_line_t         line_q;
    logic             timed, expire, done, err_n;

    always_comb begin
        timed   = is_timed(st);
        hold_nx = {1'b0, hold} + ONE_T;
        expire  = timed && (hold_nx >= {1'b0, timeout});
        done    = (dwell == '0);
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        err_n    = 1'b0;
        case (st)
            S_OWN_STOP: if (ta_req) begin
                nxt = S_G_10A; load = 1'b1; load_val = unit_len - ONE_D;
            end
            S_G_10A: if (done) begin
                nxt = S_G_00A; load = 1'b1; load_val = unit_len - ONE_D;
            end
            S_G_00A: if (done) begin
                nxt = S_G_10B; load = 1'b1; load_val = unit_len - ONE_D;
            end
            S_G_10B: if (done) begin
                nxt = S_G_BRIDGE; load = 1'b1; load_val = bridge_len - ONE_D;
            end
            S_G_BRIDGE: if (done) nxt = S_R_RETURN;
            S_R_RETURN: begin
                if (line == LN_11) nxt = S_IDLE;
                else if (expire) begin nxt = S_RESYNC; err_n = 1'b1; end
            end
            S_RESYNC: if (line == LN_11) nxt = S_IDLE;
            S_IDLE: begin
                if (line == LN_10) nxt = S_R_10A;
                else if (line != LN_11) nxt = S_RESYNC;
            end
            S_R_10A: begin
                if (line == LN_00) nxt = S_R_00A;
                else if (line == LN_11) nxt = S_IDLE;
                else if (line == LN_01) nxt = S_RESYNC;
                else if (expire) begin nxt = S_RESYNC; err_n = 1'b1; end
            end
            S_R_00A: begin
                if (line == LN_10) nxt = S_R_10B;
                else if (line == LN_11) nxt = S_IDLE;
                else if (line == LN_01) nxt = S_RESYNC;
                else if (expire) begin nxt = S_RESYNC; err_n = 1'b1; end
            end
            S_R_10B: begin
                if (line == LN_00) begin
                    nxt = S_R_SETTLE; load = 1'b1; load_val = settle_len - ONE_D;
                end
                else if (line == LN_11) nxt = S_IDLE;
                else if (line == LN_01) nxt = S_RESYNC;
                else if (expire) begin nxt = S_RESYNC; err_n = 1'b1; end
            end
            S_R_SETTLE: if (done) begin
                nxt = S_T_BRIDGE; load = 1'b1; load_val = claim_len - ONE_D;
            end
            S_T_BRIDGE: if (done) begin
                nxt = S_T_10; load = 1'b1; load_val = unit_len - ONE_D;
            end
            S_T_10: if (done) nxt = S_OWN_STOP;
            default: nxt = S_RESYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RST;
            dwell  <= '0;
            hold   <= '0;
            line_q <= LN_11;
            err    <= 1'b0;
        end else begin
            st     <= nxt;
            line_q <= line;
            err    <= err_n;
            if (load) dwell <= load_val;
            else if (!done) dwell <= dwell - ONE_D;
            if ((nxt != st) || (line != line_q)) hold <= '0;
            else if (timed && (hold != '1)) hold <= hold_nx[TMO_W-1:0];
        end
    end

    assign drv = drive_of(st);
endmodule

// File: rtl/lane_turnaround.sv
module lane_turnaround
    import lta_pkg::*;
#(
    parameter int LPX_W       = 8,
    parameter int LPX_MIN     = 13,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit RESET_OWNER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LPX_W-1:0] cfg_lpx,
    input  logic [LPX_W:0]   cfg_sure,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             ta_req,
    input  logic [1:0]       lp_in,
    output logic [1:0]       lp_out,
    output logic             lp_oe,
    output logic             owner,
    output logic             ta_err
);
    localparam int DW = LPX_W + 3;

    logic [1:0]    line_s;
    logic [DW-1:0] unit_len, settle_len, bridge_len, claim_len;
    lta_drive_t    drv;

    lta_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst(rst), .d(lp_in), .q(line_s)
    );

    lta_timing #(.LPX_W(LPX_W), .LPX_MIN(LPX_MIN), .DW(DW)) u_timing (
        .cfg_lpx(cfg_lpx), .cfg_sure(cfg_sure),
        .unit_len(unit_len), .settle_len(settle_len),
        .bridge_len(bridge_len), .claim_len(claim_len)
    );

    lta_fsm #(.DW(DW), .TMO_W(TMO_W), .RESET_OWNER(RESET_OWNER)) u_fsm (
        .clk(clk), .rst(rst), .ta_req(ta_req), .line(lp_line_t'(line_s)),
        .unit_len(unit_len), .settle_len(settle_len),
        .bridge_len(bridge_len), .claim_len(claim_len),
        .timeout(cfg_timeout), .drv(drv), .err(ta_err)
    );

    assign lp_out = drv.line;
    assign lp_oe  = drv.oe;
    assign owner  = drv.owner;
endmodule

// File: rtl/lane_turnaround_chk.sv
module lane_turnaround_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lp_out,
    input logic       lp_oe,
    input logic       owner,
    input logic       ta_err
);
    // R2: release only ever follows the driven bridge
    a_r2_release_after_bridge: assert property (@(posedge clk) disable iff (rst)
        $fell(lp_oe) |-> ($past(lp_out) == 2'b00 && !owner));

    // R2, R7: holding the lane means driving it
    a_r7_owner_drives: assert property (@(posedge clk) disable iff (rst)
        owner |-> lp_oe);

    // R5: a takeover starts with the bridge and without ownership
    a_r5_claim_starts_bridge: assert property (@(posedge clk) disable iff (rst)
        $rose(lp_oe) |-> (lp_out == 2'b00 && !owner));

    // R7: ownership arrives with stop, right after first-wire-high
    a_r7_owner_on_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(owner) |-> (lp_out == 2'b11 && $past(lp_out) == 2'b10));

    // R8: error is a single-cycle pulse
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
        ta_err |=> !ta_err);

    // R8: error never coincides with driving
    a_r8_err_no_drive: assert property (@(posedge clk) disable iff (rst)
        ta_err |-> !lp_oe);
endmodule

bind lane_turnaround lane_turnaround_chk u_chk (
    .clk(clk), .rst(rst), .lp_out(lp_out), .lp_oe(lp_oe),
    .owner(owner), .ta_err(ta_err)
);

// File: tb/lane_turnaround_tb.sv
`timescale 1ns/1ps
module lane_turnaround_tb;
    localparam int SYNC = 2;
    localparam int LMIN = 13;
    localparam int TMAX = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_lpx = 8'd20;
    logic [8:0] cfg_sure = 9'd30;
    logic [15:0] cfg_timeout = 16'd600;
    logic       ta_req = 1'b0;
    logic [1:0] rem_line = 2'b11;
    logic [1:0] lp_in;
    logic [1:0] dut_out;
    logic       dut_oe, dut_own, dut_err;

    int n_chk = 0, n_fail = 0, err_seen = 0;
    bit finished = 0;

    logic [1:0] tr_out [TMAX];
    logic       tr_oe  [TMAX];
    logic       tr_own [TMAX];
    logic       tr_err [TMAX];

    always #2 clk = ~clk;

    assign lp_in = dut_oe ? dut_out : rem_line;

    lane_turnaround u_dut (
        .clk(clk), .rst(rst), .cfg_lpx(cfg_lpx), .cfg_sure(cfg_sure),
        .cfg_timeout(cfg_timeout), .ta_req(ta_req), .lp_in(lp_in),
        .lp_out(dut_out), .lp_oe(dut_oe), .owner(dut_own), .ta_err(dut_err)
    );

    always @(negedge clk) if (!rst && dut_err) err_seen++;

    function automatic int unit_of(int c);
        return (c < LMIN) ? LMIN : c;
    endfunction

    function automatic int settle_of(int s, int u);
        if (s < u) return u;
        if (s > 2*u) return 2*u;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ta_req = 1'b0;
            tr_out[i] = dut_out; tr_oe[i] = dut_oe;
            tr_own[i] = dut_own; tr_err[i] = dut_err;
        end
    endtask

    function automatic int run_from(int s, logic [1:0] v);
        int n = 0;
        while (s + n < TMAX && tr_oe[s+n] && tr_out[s+n] == v) n++;
        return n;
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2 give pattern, R3 unit floor, R10 clean return, R4 ignored request
    task automatic give(input int u);
        int idx = 0, n, e0;
        logic [1:0] vals [4];
        int lens [4];
        bit own_ok = 1;
        vals = '{2'b10, 2'b00, 2'b10, 2'b00};
        lens = '{u, u, u, 4*u};
        rem_line = 2'b00;
        @(negedge clk); ta_req = 1'b1;
        capture(7*u + 10);
        for (int k = 0; k < 4; k++) begin
            n = run_from(idx, vals[k]);
            check(n == lens[k], (k == 3) ? "R2 bridge" : "R3 unit run", n, lens[k]);
            idx += n;
        end
        for (int i = 0; i < idx; i++) if (!tr_own[i]) own_ok = 0;
        check(own_ok, "R2 owner during give", own_ok, 1);
        check(!tr_oe[idx] && !tr_own[idx], "R2 release", {tr_oe[idx], tr_own[idx]}, 0);
        e0 = err_seen;
        ta_req = 1'b1;
        wait_cycles(2);
        ta_req = 1'b0;
        wait_cycles($urandom_range(5, 40));
        check(!dut_oe, "R4 request ignored", dut_oe, 0);
        rem_line = 2'b10; wait_cycles($urandom_range(3, 12));
        rem_line = 2'b11; wait_cycles(8);
        check(err_seen == e0 && !dut_oe, "R10 clean return", err_seen - e0, 0);
    endtask

    // R5 detect and settle, R6 clamp, R7 claim pattern
    task automatic receive(input int u, input int s);
        int f = -1, n;
        rem_line = 2'b10; wait_cycles($urandom_range(3, 15));
        rem_line = 2'b00; wait_cycles($urandom_range(3, 15));
        rem_line = 2'b10; wait_cycles($urandom_range(3, 15));
        check(!dut_oe, "R5 no drive before bridge", dut_oe, 0);
        @(negedge clk); rem_line = 2'b00;
        capture(SYNC + s + 6*u + 6);
        for (int i = 0; i < TMAX && f < 0; i++) if (tr_oe[i]) f = i;
        check(f == SYNC + s, "R6 settle", f, SYNC + s);
        if (f < 0) f = 0;
        n = run_from(f, 2'b00);
        check(n == 5*u, "R7 claim bridge", n, 5*u);
        n = run_from(f + 5*u, 2'b10);
        check(n == u, "R7 claim 10", n, u);
        check(tr_oe[f+6*u] && tr_out[f+6*u] == 2'b11 && tr_own[f+6*u] && !tr_own[f+6*u-1],
              "R7 stop and owner", {tr_out[f+6*u], tr_own[f+6*u]}, 7);
    endtask

    task automatic round(input int lpx, input int sure);
        int u, s;
        cfg_lpx = 8'(lpx); cfg_sure = 9'(sure);
        u = unit_of(lpx); s = settle_of(sure, u);
        give(u);
        receive(u, s);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        summary();
    end

    initial begin : main
        int e0, first;
        void'($urandom(32'h5A17));
        wait_cycles(4);
        check(dut_oe && dut_out == 2'b11 && dut_own && !dut_err, "R1 reset",
              {dut_oe, dut_out, dut_own}, 4'b1111);
        @(negedge clk); rst = 1'b0;
        wait_cycles(3);
        check(dut_oe && dut_out == 2'b11 && dut_own, "R1 after reset",
              {dut_oe, dut_out, dut_own}, 4'b1111);

        round(20, 30);
        round(5, 0);      // floor and lower clamp
        round(20, 200);   // upper clamp
        round(0, 26);     // zero unit -> floor; settle at 2*unit

        // R9: abandoned sequence, then a full handover still works
        give(unit_of(0));
        e0 = err_seen;
        rem_line = 2'b10; wait_cycles(6);
        rem_line = 2'b00; wait_cycles(6);
        rem_line = 2'b11; wait_cycles(40);
        check(!dut_oe && err_seen == e0, "R9 abort quiet", err_seen - e0, 0);
        receive(unit_of(0), settle_of(26, unit_of(0)));

        // R8: stalled sequence
        give(unit_of(0));
        cfg_timeout = 16'd100;
        @(negedge clk); rem_line = 2'b10;
        capture(140);
        first = -1;
        for (int i = 0; i < 140 && first < 0; i++) if (tr_err[i]) first = i;
        check(first >= 100 && first <= 100 + SYNC + 3, "R8 timeout window", first, 100 + SYNC);
        begin
            int cnt = 0;
            bit drv = 0;
            for (int i = 0; i < 140; i++) begin
                if (tr_err[i]) cnt++;
                if (tr_oe[i]) drv = 1;
            end
            check(cnt == 1 && !drv, "R8 single pulse no drive", cnt, 1);
        end
        rem_line = 2'b00; wait_cycles(10);
        check(!dut_oe, "R8 resync waits", dut_oe, 0);
        rem_line = 2'b11; wait_cycles(8);
        cfg_timeout = 16'd600;
        receive(unit_of(0), settle_of(26, unit_of(0)));

        for (int it = 0; it < 6; it++) round($urandom_range(0, 40), $urandom_range(0, 90));

        summary();
    end
endmodule